// File: doc/BRIEF.md
# Floating-Point Numeric Minimum/Maximum Unit

This block takes two IEEE-754 operands and returns their numeric minimum or numeric maximum. It works on either single-precision values (the low 32 bits of each operand bus) or double-precision values (the full 64 bits). The operation, the precision and the validity of the request are all decoded from a 32-bit instruction word presented next to the operands.

The selection follows numeric-preference rules. When only one operand is a NaN, the numeric operand wins. Negative zero is treated as smaller than positive zero. A result that would be a NaN, which can only happen when both inputs are NaN, is replaced by the canonical default NaN of the selected precision.

The result is registered, so it appears one clock after the request strobe. An instruction word that does not match the recognised pattern raises a flag in that same next cycle and leaves the result register untouched.

Top module: `fp_minmax_unit`

## Requirements
- R1: A request is recognised only when instr[23:20] = 4'h4, instr[11:9] = 3'b101 and instr[4] = 0. If `in_valid` is high with any other pattern, `bad_enc` is high in the next cycle, `res_valid` stays low and `result` keeps its previous value.
- R2: instr[8] selects the precision. A 1 selects double precision on all 64 operand bits. A 0 selects single precision on bits [31:0] and ignores the upper bits.
- R3: instr[6] selects the operation. A 1 returns the minimum and a 0 returns the maximum.
- R4: When exactly one operand is a NaN (exponent all ones, mantissa nonzero, quiet or signaling alike), the other operand is returned unchanged.
- R5: Between -0 and +0, the minimum returns -0 and the maximum returns +0, whichever operand position each zero is in.
- R6: When both operands are NaN, the result is the default NaN: 32'h7FC00000 in single precision and 64'h7FF8000000000000 in double precision.
- R7: In single precision, result[63:32] is zero.
- R8: Ordering is numeric. Any negative value is below any positive value. Two positive values order by magnitude, two negative values order in reverse of magnitude, and infinities take part as ordinary extremes.
- R9: `res_valid` and `bad_enc` are registered one cycle after `in_valid`, are low when `in_valid` was low, and are cleared by the active-low synchronous reset, which also clears `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word carrying operation and precision |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| res_valid | output | 1 | Result valid, one cycle after a recognised request |
| bad_enc | output | 1 | Unrecognised encoding flag, one cycle after the request |
| result | output | 64 | Selected or default-NaN result |

## Verification
A wrong decode shows up in the cycle after the request. The valid strobe and the encoding flag come out inverted, or the precision is misread, which leaves garbage in the upper half or compares the wrong fields. A wrong ordering or a wrong NaN classification shows up on the very next result. The operand pairs are chosen so that the two possible picks always differ in a way visible on the bus: opposite signs, adjacent mantissas, zeros of opposite sign, and NaN paired against a number. A broken hold path shows up as a result that changes after a rejected or idle cycle.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int DW = 64;
  localparam int SW = 32;
  localparam int IW = 32;
  localparam int DP_EXP_W = 11;
  localparam int SP_EXP_W = 8;
  localparam int DP_MAN_W = DW - 1 - DP_EXP_W;
  localparam int SP_MAN_W = SW - 1 - SP_EXP_W;
  localparam int MAG_W = DW - 1;

  localparam int OPC_LO = 20;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_VAL = 4'h4;
  localparam int CP_LO = 9;
  localparam int CP_W = 3;
  localparam logic [CP_W-1:0] CP_VAL = 3'b101;
  localparam int ZERO_BIT = 4;
  localparam int SIZE_BIT = 8;
  localparam int MIN_BIT = 6;

  localparam logic [DW-1:0] DP_QNAN = {1'b0, {DP_EXP_W{1'b1}}, 1'b1, {(DP_MAN_W-1){1'b0}}};
  localparam logic [SW-1:0] SP_QNAN = {1'b0, {SP_EXP_W{1'b1}}, 1'b1, {(SP_MAN_W-1){1'b0}}};

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } fp_view_t;

  function automatic fp_view_t view_of(input logic [DW-1:0] x, input logic dbl);
    fp_view_t v;
    if (dbl) begin
      v.sign = x[DW-1];
      v.mag  = x[MAG_W-1:0];
      v.nan  = (&x[DW-2 -: DP_EXP_W]) && (|x[DP_MAN_W-1:0]);
    end else begin
      v.sign = x[SW-1];
      v.mag  = {{(MAG_W-SW+1){1'b0}}, x[SW-2:0]};
      v.nan  = (&x[SW-2 -: SP_EXP_W]) && (|x[SP_MAN_W-1:0]);
    end
    v.zero = (v.mag == '0);
    return v;
  endfunction

  // strictly-less on two non-NaN views; zeros of either sign tie
  function automatic logic below(input fp_view_t a, input fp_view_t b);
    if (a.nan || b.nan) return 1'b0;
    if (a.zero && b.zero) return 1'b0;
    if (a.sign != b.sign) return a.sign;
    if (!a.sign) return a.mag < b.mag;
    return a.mag > b.mag;
  endfunction
endpackage

// File: rtl/fpmm_decode.sv
module fpmm_decode
  import fpmm_pkg::*;
(
  input  logic [IW-1:0] instr,
  output logic          known,
  output logic          dbl,
  output logic          take_min
);
  always_comb begin
    known    = (instr[OPC_LO +: OPC_W] == OPC_VAL) &&
               (instr[CP_LO +: CP_W] == CP_VAL) &&
               !instr[ZERO_BIT];
    dbl      = instr[SIZE_BIT];
    take_min = instr[MIN_BIT];
  end
endmodule

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int N_OPS = 2
) (
  input  logic [N_OPS-1:0][DW-1:0] ops,
  input  logic                     dbl,
  output fp_view_t [N_OPS-1:0]     views
);
  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    assign views[i] = view_of(ops[i], dbl);
  end
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
  import fpmm_pkg::*;
(
  input  fp_view_t        va,
  input  fp_view_t        vb,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic            dbl,
  input  logic            take_min,
  output logic            pick_a,
  output logic            tie,
  output logic            nan_out,
  output logic [DW-1:0]   value
);
  logic a_lt_b, b_lt_a, a_wins, b_wins;
  logic [DW-1:0] chosen, a_fmt, b_fmt;

  always_comb begin
    a_lt_b = below(va, vb);
    b_lt_a = below(vb, va);
    a_wins = (take_min ? a_lt_b : b_lt_a) || vb.nan;
    b_wins = (take_min ? b_lt_a : a_lt_b) || va.nan;
    tie    = !a_wins && !b_wins;
    if (a_wins)       pick_a = 1'b1;
    else if (b_wins)  pick_a = 1'b0;
    else              pick_a = take_min ? va.sign : !va.sign;

    a_fmt  = dbl ? opa : {{(DW-SW){1'b0}}, opa[SW-1:0]};
    b_fmt  = dbl ? opb : {{(DW-SW){1'b0}}, opb[SW-1:0]};
    chosen = pick_a ? a_fmt : b_fmt;
    nan_out = pick_a ? va.nan : vb.nan;
    if (nan_out) value = dbl ? DP_QNAN : {{(DW-SW){1'b0}}, SP_QNAN};
    else         value = chosen;
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fpmm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [63:0]   opa,
  input  logic [63:0]   opb,
  output logic          res_valid,
  output logic          bad_enc,
  output logic [63:0]   result
);
  logic known, dbl, take_min;
  fp_view_t [1:0] views;
  logic pick_a, tie, nan_out;
  logic [DW-1:0] value;
  logic dbl_q;
  logic accept;

  fpmm_decode u_dec (.instr(instr), .known(known), .dbl(dbl), .take_min(take_min));

  fpmm_classify #(.N_OPS(2)) u_cls (.ops({opb, opa}), .dbl(dbl), .views(views));

  fpmm_select u_sel (
    .va(views[0]), .vb(views[1]), .opa(opa), .opb(opb), .dbl(dbl),
    .take_min(take_min), .pick_a(pick_a), .tie(tie), .nan_out(nan_out), .value(value)
  );

  assign accept = in_valid && known;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      bad_enc   <= 1'b0;
      result    <= '0;
      dbl_q     <= 1'b0;
    end else begin
      res_valid <= accept;
      bad_enc   <= in_valid && !known;
      if (accept) begin
        result <= value;
        dbl_q  <= dbl;
      end
    end
  end
endmodule

// File: rtl/fpmm_checker.sv
module fpmm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        res_valid,
  input logic        bad_enc,
  input logic        dbl_q,
  input logic [63:0] result
);
  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_valid, bad_enc}));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(result));
  p_canon_dp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && dbl_q && (&result[62:52]) && (|result[51:0])) |-> result == 64'h7FF8000000000000);
  p_canon_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !dbl_q && (&result[30:23]) && (|result[22:0])) |-> result[31:0] == 32'h7FC00000);
  p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !dbl_q) |-> result[63:32] == 32'h0);
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || bad_enc) |-> $past(in_valid));
endmodule

bind fp_minmax_unit fpmm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_valid(res_valid),
  .bad_enc(bad_enc), .dbl_q(dbl_q), .result(result)
);

// File: tb/fp_minmax_unit_bench.sv
module fp_minmax_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SMAX = 32'h00400A00, SMIN = 32'h00400A40;
  localparam logic [31:0] DMAX = 32'h00400B00, DMIN = 32'h00400B40;
  localparam int NV = 18;
  // {instr, opa, opb, expected}
  localparam logic [223:0] VEC [NV] = '{
    {SMIN, 64'h3F800000, 64'h40000000, 64'h3F800000},  // R3 R8
    {SMAX, 64'h3F800000, 64'h40000000, 64'h40000000},  // R3 R8
    {SMIN, 64'hBF800000, 64'hC0000000, 64'hC0000000},  // R8 negatives
    {SMAX, 64'hBF800000, 64'hC0000000, 64'hBF800000},  // R8
    {SMIN, 64'h7FC00001, 64'h40000000, 64'h40000000},  // R4
    {SMAX, 64'h3F800000, 64'h7F800001, 64'h3F800000},  // R4 signaling
    {SMIN, 64'h00000000, 64'h80000000, 64'h80000000},  // R5
    {SMAX, 64'h80000000, 64'h00000000, 64'h00000000},  // R5
    {SMIN, 64'h7FC00001, 64'h7F800001, 64'h7FC00000},  // R6
    {SMAX, 64'h7F800000, 64'hBF800000, 64'h7F800000},  // R8 infinity
    {SMIN, 64'hFFFFFFFF3F800000, 64'h1234567840000000, 64'h3F800000}, // R2 R7
    {DMIN, 64'h3FF0000000000000, 64'hC008000000000000, 64'hC008000000000000}, // R2
    {DMAX, 64'h3FF0000000000000, 64'h4000000000000000, 64'h4000000000000000}, // R3
    {DMAX, 64'h7FF0000000000001, 64'hC008000000000000, 64'hC008000000000000}, // R4
    {DMIN, 64'h8000000000000000, 64'h0000000000000000, 64'h8000000000000000}, // R5
    {DMAX, 64'h8000000000000000, 64'h8000000000000000, 64'h8000000000000000}, // R5
    {DMIN, 64'h7FF0000000000001, 64'hFFF8000000000005, 64'h7FF8000000000000}, // R6
    {DMIN, 64'h3FF0000000000001, 64'h3FF0000000000000, 64'h3FF0000000000000}  // R8
  };

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] instr = '0;
  logic [63:0] opa = '0, opb = '0;
  logic res_valid, bad_enc;
  logic [63:0] result;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_minmax_unit u_fp_minmax_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .opa(opa), .opb(opb), .res_valid(res_valid), .bad_enc(bad_enc), .result(result)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1; instr = i; opa = a; opb = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", {63'b0, res_valid}, 64'd0);
    check("R9 reset flag", {63'b0, bad_enc}, 64'd0);
    check("R9 reset result", result, 64'd0);
    rst_n = 1;

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k][223:192], VEC[k][191:128], VEC[k][127:64]);
      check($sformatf("R2-vector%0d valid", k), {62'b0, res_valid, bad_enc}, 64'd2);
      check($sformatf("R3-R8 vector%0d result", k), result, VEC[k][63:0]);
    end

    // R1: bad opcode field, result held at last value
    issue(32'h00500A40, 64'h1, 64'h2);
    check("R1 bad flag", {62'b0, res_valid, bad_enc}, 64'd1);
    check("R1 hold", result, 64'h3FF0000000000000);
    // R1: bit 4 set
    issue(32'h00400A50, 64'h1, 64'h2);
    check("R1 bit4 flag", {62'b0, res_valid, bad_enc}, 64'd1);
    check("R1 bit4 hold", result, 64'h3FF0000000000000);
    // R9: idle cycle
    @(negedge clk);
    check("R9 idle", {62'b0, res_valid, bad_enc}, 64'd0);
    // R9: reset mid-stream
    @(negedge clk);
    in_valid = 1; instr = SMAX; opa = 64'h3F800000; opb = 64'h0;
    @(negedge clk);
    in_valid = 0; rst_n = 0;
    @(negedge clk);
    check("R9 reset clears", {62'b0, res_valid, bad_enc}, 64'd0);
    check("R9 reset result", result, 64'd0);
    rst_n = 1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule